// File: doc/BRIEF.md
# Bit-Interleaved Permutation Engine

This block applies a lightweight-cipher permutation to a 320-bit state of five 64-bit lanes. It executes one round per clock cycle. A round-count select chooses a full 12-round pass, a 6-round pass or a single round. A surrounding mode-of-operation controller drives it by presenting a state, pulsing `start` and waiting for `done`. It then reads the permuted state back from the output port.

Internally the engine never holds a lane as a plain 64-bit word. At load, each lane is byte-reversed and then split into a word made of its even-indexed bits and a word made of its odd-indexed bits. All substitution and diffusion work runs on these 32-bit halves. A 64-bit rotation by an odd amount turns into a pair of 32-bit rotations that trade halves. The round constant is split into an even part and an odd part in the same way. The output port merges the halves back into lanes and reverses the bytes again.

Top module: `perm_engine`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and `state_out` is all zeros. A reset in the middle of a run also returns the block to this state.
- R2: `rounds_sel` selects the number of rounds. A value of 0 gives 12 rounds. Round index i (0..11) uses the constant `0xF0 - 0x0F*i`, XORed into the low byte of lane x2.
- R3: The engine accepts `start` when it is idle. `busy` then reads 1 for exactly N cycles, beginning the cycle after the accepting edge. `done` reads 1 in the cycle after the last busy cycle. At that point `state_out` holds the result of N rounds.
- R4: A `rounds_sel` value of 1 gives 6 rounds, using round indices 6..11.
- R5: A `rounds_sel` value of 2 gives 1 round, using round index 11 (constant 0x4B). A value of 3 acts like 0 and gives 12 rounds.
- R6: Lane k occupies bits [64k+63:64k] of `state_in` and of `state_out`. Byte j of a port lane sits at bits [8j+7:8j]. It is weighted as the (7-j)-th byte of the lane value, so port byte 0 becomes the most significant byte of that value. The output lanes use the same layout.
- R7: Each round does three things. It adds the constant, then applies the 5-bit substitution layer (the standard form of this permutation, with the final complement on x2). It then applies the lane diffusion, which XORs each lane with two right-rotations of itself: x0 by 19/28, x1 by 61/39, x2 by 1/6, x3 by 10/17 and x4 by 7/41.
- R8: While `busy` is 1, `start` has no effect. The running pass keeps its round count and its result.
- R9: `done` lasts exactly one cycle. While the engine is idle and `start` is low, `state_out` does not change, even when `state_in` changes.
- R10: The round index stays in the range 0..11 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a pass with the presented state (taken only when idle) |
| rounds_sel | input | 2 | Round count: 0 or 3 = 12, 1 = 6, 2 = 1 |
| state_in | input | 320 | State to permute, five lanes in port byte order |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse when the pass ends |
| state_out | output | 320 | Current state merged back to lanes in port byte order |

## Verification
Some properties are checked on every cycle: the one-cycle `done` pulse, the idle-accept of `start`, the advance of the round index while a `start` arriving mid-pass is ignored, the range of that index, and the stability of `state_out` while idle. The values of the permutation can only be shown by the bench's scenarios. These cover the interleaved halves, the split constants, the byte reversal and the half-swapping rotations, and each result is compared against a plain 64-bit model. The scenarios also cover the exact busy length for each select value and the recovery from a reset in the middle of a pass.

// File: rtl/perm_pkg.sv
// Shared types and helpers for the permutation engine.
// Assumes 64-bit lanes split into two 32-bit halves.
package perm_pkg;
    localparam int LANES  = 5;
    localparam int LANE_W = 64;
    localparam int HALF_W = LANE_W / 2;
    localparam int NUM_RC = 12;
    localparam int CNT_W  = $clog2(NUM_RC);
    localparam int STATE_W = LANES * LANE_W;

    typedef struct packed {
        logic [HALF_W-1:0] odd;
        logic [HALF_W-1:0] even;
    } half_pair_t;

    typedef half_pair_t [LANES-1:0] istate_t;

    // Reverse the byte order of one lane.
    function automatic logic [LANE_W-1:0] byte_rev(input logic [LANE_W-1:0] x);
        logic [LANE_W-1:0] r;
        for (int j = 0; j < LANE_W/8; j++)
            r[8*j +: 8] = x[LANE_W-8-8*j +: 8];
        return r;
    endfunction

    // Gather even-indexed bits into one half, odd-indexed bits into the other.
    function automatic half_pair_t split_bits(input logic [LANE_W-1:0] x);
        half_pair_t p;
        for (int k = 0; k < HALF_W; k++) begin
            p.even[k] = x[2*k];
            p.odd[k]  = x[2*k+1];
        end
        return p;
    endfunction

    // Inverse of split_bits.
    function automatic logic [LANE_W-1:0] merge_bits(input half_pair_t p);
        logic [LANE_W-1:0] x;
        for (int k = 0; k < HALF_W; k++) begin
            x[2*k]   = p.even[k];
            x[2*k+1] = p.odd[k];
        end
        return x;
    endfunction

    // Right rotation of a 32-bit half by a nonzero amount.
    function automatic logic [HALF_W-1:0] ror32(input logic [HALF_W-1:0] x, input int r);
        return (x >> r) | (x << (HALF_W - r));
    endfunction

    // Round constant for index i, delivered already split into halves.
    function automatic half_pair_t round_const(input logic [CNT_W-1:0] i);
        logic [7:0] c8;
        c8 = 8'hF0 - 8'(8'h0F * i);
        return split_bits({{(LANE_W-8){1'b0}}, c8});
    endfunction
endpackage

// File: rtl/perm_lane_conv.sv
// Boundary converters: byte-reverse plus interleave on load,
// de-interleave plus byte-reverse on unload. Purely combinational.
module perm_lane_conv
    import perm_pkg::*;
(
    input  logic [STATE_W-1:0] port_in,
    output istate_t            load_state,
    input  istate_t            held_state,
    output logic [STATE_W-1:0] port_out
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Convert one lane in each direction.
        always_comb begin
            load_state[k] = split_bits(byte_rev(port_in[LANE_W*k +: LANE_W]));
            port_out[LANE_W*k +: LANE_W] = byte_rev(merge_bits(held_state[k]));
        end
    end
endmodule

// File: rtl/perm_round.sv
// One permutation round on the interleaved state: constant addition,
// substitution on both half planes, then half-pair diffusion.
module perm_round
    import perm_pkg::*;
(
    input  istate_t    s_in,
    input  half_pair_t rc,
    output istate_t    s_out
);
    logic [HALF_W-1:0] a0, a1, a2, a3, a4, tn;
    logic [HALF_W-1:0] t0, t1;
    istate_t sb;

    // Substitution layer, applied to the even plane then the odd plane.
    always_comb begin
        sb = s_in;
        for (int h = 0; h < 2; h++) begin
            a0 = h == 0 ? s_in[0].even : s_in[0].odd;
            a1 = h == 0 ? s_in[1].even : s_in[1].odd;
            a2 = h == 0 ? s_in[2].even : s_in[2].odd;
            a3 = h == 0 ? s_in[3].even : s_in[3].odd;
            a4 = h == 0 ? s_in[4].even : s_in[4].odd;
            a0 = a0 ^ a4;
            a4 = a4 ^ a3;
            a2 = a2 ^ a1 ^ (h == 0 ? rc.even : rc.odd);
            tn = a4 | ~a0;
            a0 = a0 ^ (a2 & ~a1);
            a2 = a2 ^ (a3 | ~a4);
            a4 = a4 ^ (a1 & ~a0);
            a1 = a1 ^ (a3 & a2);
            a3 = a3 ^ tn;
            a1 = a1 ^ a0;
            a3 = a3 ^ a2;
            a0 = a0 ^ a4;
            if (h == 0) begin
                sb[0].even = a0; sb[1].even = a1; sb[2].even = a2;
                sb[3].even = a3; sb[4].even = a4;
            end else begin
                sb[0].odd = a0; sb[1].odd = a1; sb[2].odd = a2;
                sb[3].odd = a3; sb[4].odd = a4;
            end
        end
    end

    // Diffusion layer: 64-bit rotations expressed on the half pairs.
    always_comb begin
        t0 = sb[0].even ^ ror32(sb[0].odd, 4);
        t1 = sb[0].odd  ^ ror32(sb[0].even, 5);
        s_out[0].odd  = sb[0].odd  ^ ror32(t0, 10);
        s_out[0].even = sb[0].even ^ ror32(t1, 9);

        t0 = sb[1].even ^ ror32(sb[1].even, 11);
        t1 = sb[1].odd  ^ ror32(sb[1].odd, 11);
        s_out[1].odd  = sb[1].odd  ^ ror32(t0, 20);
        s_out[1].even = sb[1].even ^ ror32(t1, 19);

        t0 = sb[2].even ^ ror32(sb[2].odd, 2);
        t1 = sb[2].odd  ^ ror32(sb[2].even, 3);
        s_out[2].odd  = sb[2].odd  ^ ror32(t0, 1);
        s_out[2].even = sb[2].even ^ t1;

        t0 = sb[3].even ^ ror32(sb[3].odd, 3);
        t1 = sb[3].odd  ^ ror32(sb[3].even, 4);
        s_out[3].even = sb[3].even ^ ror32(t0, 5);
        s_out[3].odd  = sb[3].odd  ^ ror32(t1, 5);

        t0 = sb[4].even ^ ror32(sb[4].even, 17);
        t1 = sb[4].odd  ^ ror32(sb[4].odd, 17);
        s_out[4].odd  = sb[4].odd  ^ ror32(t0, 4);
        s_out[4].even = sb[4].even ^ ror32(t1, 3);
    end
endmodule

// File: rtl/perm_ctrl.sv
// Round sequencer: takes start only when idle, steps the round index
// from the select-dependent offset up to the last table entry, then pulses done.
module perm_ctrl
    import perm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       rounds_sel,
    output logic             busy,
    output logic             done,
    output logic             accept,
    output logic [CNT_W-1:0] rnd_idx
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_RC - 1);
    localparam logic [CNT_W-1:0] OFS_HALF = CNT_W'(NUM_RC / 2);

    logic [CNT_W-1:0] offset;

    // Start is honoured only when no pass is running.
    assign accept = start && !busy;

    // Pick the first round index from the select.
    always_comb begin
        case (rounds_sel)
            2'd1:    offset = OFS_HALF;
            2'd2:    offset = LAST;
            default: offset = '0;
        endcase
    end

    // Busy, done and round index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            rnd_idx <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            done    <= 1'b0;
            rnd_idx <= offset;
        end else if (busy) begin
            if (rnd_idx == LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                rnd_idx <= rnd_idx + 1'b1;
                done    <= 1'b0;
            end
        end else begin
            done <= 1'b0;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && rnd_idx != LAST) |=> (busy && rnd_idx == $past(rnd_idx) + 1'b1)); // R8
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_idx <= LAST); // R10
endmodule

// File: rtl/perm_engine.sv
// Top of the permutation engine. Holds the interleaved state register,
// loads it through the converters on an accepted start and advances it one
// round per busy cycle. The output is the held state merged back to lanes.
module perm_engine
    import perm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         rounds_sel,
    input  logic [STATE_W-1:0] state_in,
    output logic               busy,
    output logic               done,
    output logic [STATE_W-1:0] state_out
);
    istate_t          st_q, st_load, st_next;
    logic             accept;
    logic [CNT_W-1:0] rnd_idx;

    perm_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .rounds_sel(rounds_sel),
        .busy(busy), .done(done), .accept(accept), .rnd_idx(rnd_idx)
    );

    perm_lane_conv u_conv (
        .port_in(state_in), .load_state(st_load),
        .held_state(st_q), .port_out(state_out)
    );

    perm_round u_round (
        .s_in(st_q), .rc(round_const(rnd_idx)), .s_out(st_next)
    );

    // State register: load on accept, step while busy, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      st_q <= '0;
        else if (accept) st_q <= st_load;
        else if (busy)   st_q <= st_next;
    end

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(state_out)); // R9
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R3
endmodule

// File: tb/test_perm_engine.sv
module test_perm_engine;
    localparam int SW = 320;
    localparam int NV = 6;

    localparam logic [SW-1:0] VEC_IN [NV] = '{
        {SW{1'b0}},
        {SW{1'b1}},
        {5{64'h0001020304050607}},
        {{(SW-1){1'b0}}, 1'b1},
        {64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h0F1E2D3C4B5A6978,
         64'h8000000000000001, 64'hDEADBEEFCAFEF00D},
        {10{32'hA5A5_5A5A}}
    };
    localparam logic [1:0] VEC_SEL [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd2};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [1:0] rounds_sel = 2'd0;
    logic [SW-1:0] state_in = '0;
    logic busy, done;
    logic [SW-1:0] state_out;
    int checks = 0, errors = 0, cyc = 0;

    perm_engine i_perm_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .rounds_sel(rounds_sel),
        .state_in(state_in), .busy(busy), .done(done), .state_out(state_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL R3 watchdog expired act=%0d exp=<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [63:0] rotr(input logic [63:0] x, input int r);
        return (x >> r) | (x << (64 - r));
    endfunction

    function automatic logic [63:0] bswap(input logic [63:0] x);
        logic [63:0] r;
        for (int j = 0; j < 8; j++) r[8*j +: 8] = x[56-8*j +: 8];
        return r;
    endfunction

    // Plain 64-bit model of the permutation (R2, R6, R7).
    function automatic logic [SW-1:0] ref_perm(input logic [SW-1:0] p, input int first);
        logic [63:0] x [5];
        logic [63:0] t [5];
        logic [SW-1:0] q;
        for (int k = 0; k < 5; k++) x[k] = bswap(p[64*k +: 64]);
        for (int i = first; i < 12; i++) begin
            x[2] = x[2] ^ 64'(240 - 15 * i);
            x[0] ^= x[4]; x[4] ^= x[3]; x[2] ^= x[1];
            for (int k = 0; k < 5; k++) t[k] = ~x[k] & x[(k+1)%5];
            for (int k = 0; k < 5; k++) x[k] ^= t[(k+1)%5];
            x[1] ^= x[0]; x[0] ^= x[4]; x[3] ^= x[2]; x[2] = ~x[2];
            x[0] = x[0] ^ rotr(x[0], 19) ^ rotr(x[0], 28);
            x[1] = x[1] ^ rotr(x[1], 61) ^ rotr(x[1], 39);
            x[2] = x[2] ^ rotr(x[2], 1)  ^ rotr(x[2], 6);
            x[3] = x[3] ^ rotr(x[3], 10) ^ rotr(x[3], 17);
            x[4] = x[4] ^ rotr(x[4], 7)  ^ rotr(x[4], 41);
        end
        for (int k = 0; k < 5; k++) q[64*k +: 64] = bswap(x[k]);
        return q;
    endfunction

    function automatic int first_idx(input logic [1:0] s);
        return s == 2'd1 ? 6 : (s == 2'd2 ? 11 : 0);
    endfunction

    task automatic check(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Start a pass, optionally poke start again mid-pass, measure and check.
    task automatic run_pass(input logic [1:0] sel, input logic [SW-1:0] din,
                            input bit poke, input string tag);
        int n;
        int nb;
        logic [SW-1:0] exp;
        logic [SW-1:0] held;
        n = 12 - first_idx(sel);
        exp = ref_perm(din, first_idx(sel));
        @(negedge clk);
        start = 1'b1; rounds_sel = sel; state_in = din;
        @(negedge clk);
        start = 1'b0;
        nb = 0;
        while (busy && nb < 100) begin
            nb++;
            if (poke && nb == 2) begin
                start = 1'b1; rounds_sel = 2'd2; state_in = ~din;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check({tag, " busy length"}, SW'(nb), SW'(n));
        check({tag, " done"}, SW'(done), SW'(1));
        check({tag, " result"}, state_out, exp);
        held = state_out;
        state_in = ~din;
        @(negedge clk);
        check("R9 done one cycle", SW'(done), SW'(0));
        @(negedge clk);
        check("R9 idle output stable", state_out, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset busy", SW'(busy), SW'(0));
        check("R1 reset done", SW'(done), SW'(0));
        check("R1 reset state", state_out, '0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            case (VEC_SEL[v])
                2'd0: run_pass(VEC_SEL[v], VEC_IN[v], 1'b0, "R2 R7 twelve rounds");
                2'd1: run_pass(VEC_SEL[v], VEC_IN[v], 1'b0, "R4 six rounds");
                2'd2: run_pass(VEC_SEL[v], VEC_IN[v], 1'b0, "R5 R6 single round");
                default: run_pass(VEC_SEL[v], VEC_IN[v], 1'b0, "R5 select three");
            endcase
        end

        // R8: start raised mid-pass with other data and select is ignored.
        run_pass(2'd0, VEC_IN[4], 1'b1, "R8 start while busy");
        run_pass(2'd1, VEC_IN[2], 1'b1, "R8 start while busy six");

        // R3: back-to-back passes right after done.
        run_pass(2'd2, VEC_IN[1], 1'b0, "R3 back to back");

        // R1: reset during a running pass.
        @(negedge clk);
        start = 1'b1; rounds_sel = 2'd0; state_in = VEC_IN[4];
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset busy", SW'(busy), SW'(0));
        check("R1 mid-run reset done", SW'(done), SW'(0));
        check("R1 mid-run reset state", state_out, '0);
        rst_n = 1'b1;
        run_pass(2'd0, VEC_IN[5], 1'b0, "R1 R2 run after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule